// File: doc/BRIEF.md
# Shared Global Timer with Per-Core Comparators

This block is a memory-mapped timer for a cluster of up to four cores. One 64-bit up-counter, driven through an 8-bit prescaler, is shared by every core. Each core also has a private bank with the following contents:

- a 64-bit comparator;
- a 32-bit increment value;
- a sticky event flag;
- its own interrupt line.

When a core's compare condition holds, that core's flag is raised. If the core has auto-increment enabled, its comparator also moves forward by the core's increment. This gives each core a periodic tick from the one shared time base.

Software reaches the block through a 32-bit register port. Each request carries the ID of the requesting core, and that ID picks the bank for banked offsets. The request side has no back-pressure: every cycle with `req_valid` high is taken at once. A read answers exactly one cycle later on `rsp_valid`/`rsp_data`, and that answer cannot be stalled. A request whose core ID is out of range is dropped, and any read from it returns zero.

Word offsets (byte address bits 4:2) are decoded as follows:

| Byte offset | Contents |
|---|---|
| 0x00 | counter low word |
| 0x04 | counter high word |
| 0x08 | control |
| 0x0C | status |
| 0x10 | comparator low word |
| 0x14 | comparator high word |
| 0x18 | increment |

Top module: `gtimer_cluster`

## Requirements
- R1: While the timer enable (control bit 0) is set, the counter increases by exactly one every (prescaler + 1) clock cycles. The prescaler is control bits 15:8. The prescaler phase restarts from zero whenever the timer is off.
- R2: While the timer enable is clear, the counter holds its value. Writes to offsets 0x00/0x04 load the low or high counter word only while the timer is off. Such writes made while the timer runs are ignored.
- R3: A read of offset 0x00 returns the counter's low word and stores the counter's high word for the requesting core. A later read of 0x04 by that core returns the stored high word, even if the counter changed in between.
- R4: The control register at 0x08 is laid out as follows:
  - bit 0: timer enable (global);
  - bit 1: comparator enable (per core);
  - bit 2: interrupt enable (per core);
  - bit 3: auto-increment enable (per core);
  - bits 15:8: prescaler (global).

  A write from any core updates the global fields and that core's banked bits. A read returns the global fields merged with the reader's banked bits.
- R5: Offsets 0x10/0x14 (comparator), 0x18 (increment) and 0x0C (status) reach only the bank of the requesting core. Other cores' banks and interrupts are untouched.
- R6: A core's event flag (status bit 0) becomes 1 on the clock edge after a cycle in which that core's comparator enable is set and counter ≥ comparator. The flag stays 1 until it is cleared.
- R7: Writing 1 to status bit 0 clears the requesting core's flag. If the compare condition holds in the same cycle, the flag stays 1.
- R8: Each core's interrupt output is high exactly when that core's event flag and interrupt enable are both 1.
- R9: With auto-increment enabled, every cycle in which the compare condition holds adds the core's increment to its comparator. A software write to the comparator in that same cycle takes precedence.
- R10: A read request yields `rsp_valid` high for one cycle on the next clock edge, with the data. Unmapped offsets read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address; bits 4:2 select the word |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | ID of the requesting core; selects the bank |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_data | output | 32 | Read data |
| irq_o | output | 4 | One interrupt line per core |

## Verification
The bench exercises two cases where two functions act in the same cycle. In the first, a core writes 1 to its status flag while its comparator is still enabled and the counter is already past the comparator. That clear and a fresh compare hit land on the same edge, and the flag must read back as 1 (R7). Clearing again after the comparator is disabled must then yield 0.

In the second, a counter write arrives while the counter is counting. The readback must equal the count produced by the enabled cycles alone (R2).

Sweeps over the prescaler, the run length, and the counter-to-comparator distance on every core give the expected counts and flag values by plain arithmetic.

// File: rtl/gt_pkg.sv
package gt_pkg;

  // word indices (byte address bits 4:2)
  localparam logic [2:0] W_CNT_LO = 3'd0;
  localparam logic [2:0] W_CNT_HI = 3'd1;
  localparam logic [2:0] W_CTRL   = 3'd2;
  localparam logic [2:0] W_STAT   = 3'd3;
  localparam logic [2:0] W_CMP_LO = 3'd4;
  localparam logic [2:0] W_CMP_HI = 3'd5;
  localparam logic [2:0] W_INC    = 3'd6;

  // control bit positions
  localparam int B_RUN     = 0;
  localparam int B_CMP_EN  = 1;
  localparam int B_IRQ_EN  = 2;
  localparam int B_AUTO    = 3;
  localparam int B_PRE_LSB = 8;

  typedef struct packed {
    logic auto_inc;
    logic irq_en;
    logic cmp_en;
  } bank_ctl_t;

endpackage

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int CNT_W = 64,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] count_q;
  logic [PRE_W-1:0] phase_q;
  logic             step;

  assign step    = run_i && (phase_q == presc_i);
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run_i || step) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (run_i) begin
      if (step) count_q <= count_q + 1'b1;
    end else if (ld_lo_i) begin
      count_q[31:0] <= wdata_i;
    end else if (ld_hi_i) begin
      count_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !ld_lo_i && !ld_hi_i) |=> count_q == $past(count_q)); // R2

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1)); // R1

endmodule

// File: rtl/gt_bank.sv
module gt_bank
  import gt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  bank_ctl_t        ctl_i,
  input  logic             wr_cmp_lo_i,
  input  logic             wr_cmp_hi_i,
  input  logic             wr_inc_i,
  input  logic             clr_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic [31:0]      inc_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cmp_q;
  logic [31:0]      inc_q;
  logic             flag_q;
  logic             hit;
  logic [CNT_W-1:0] inc_ext;

  assign hit     = ctl_i.cmp_en && (count_i >= cmp_q);
  assign inc_ext = {{HI_W{1'b0}}, inc_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_cmp_lo_i) begin
      cmp_q[31:0] <= wdata_i;
    end else if (wr_cmp_hi_i) begin
      cmp_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
    end else if (hit && ctl_i.auto_inc) begin
      cmp_q <= cmp_q + inc_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        inc_q <= '0;
    else if (wr_inc_i) inc_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cmp_o  = cmp_q;
  assign inc_o  = inc_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ctl_i.irq_en;

  AST_HIT_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q); // R7

  AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl_i.auto_inc && !wr_cmp_lo_i && !wr_cmp_hi_i)
      |=> cmp_q == $past(cmp_q) + $past(inc_ext)); // R9

endmodule

// File: rtl/gtimer_cluster.sv
module gtimer_cluster
  import gt_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int PRE_W     = 8,
  parameter int CNT_W     = 64,
  localparam int ID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [4:0]           req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [ID_W-1:0]      req_cpu,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_data,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int HI_W = CNT_W - 32;

  logic             run_q;
  logic [PRE_W-1:0] presc_q;
  bank_ctl_t        bctl_q [NUM_CORES];
  logic [HI_W-1:0]  snap_q [NUM_CORES];

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmp_w  [NUM_CORES];
  logic [31:0]      inc_w  [NUM_CORES];
  logic [NUM_CORES-1:0] flag_w;

  logic       cpu_ok, wr, rd;
  logic [2:0] widx;
  logic [31:0] rdata;

  assign widx   = req_addr[4:2];
  assign cpu_ok = (int'(req_cpu) < NUM_CORES);
  assign wr     = req_valid && req_write && cpu_ok;
  assign rd     = req_valid && !req_write;

  // global control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      presc_q <= '0;
    end else if (wr && widx == W_CTRL) begin
      run_q   <= req_wdata[B_RUN];
      presc_q <= req_wdata[B_PRE_LSB +: PRE_W];
    end
  end

  gt_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_q),
    .presc_i (presc_q),
    .ld_lo_i (wr && widx == W_CNT_LO),
    .ld_hi_i (wr && widx == W_CNT_HI),
    .wdata_i (req_wdata),
    .count_o (count)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic mine;
    assign mine = wr && (int'(req_cpu) == c);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bctl_q[c] <= '0;
      end else if (mine && widx == W_CTRL) begin
        bctl_q[c].cmp_en   <= req_wdata[B_CMP_EN];
        bctl_q[c].irq_en   <= req_wdata[B_IRQ_EN];
        bctl_q[c].auto_inc <= req_wdata[B_AUTO];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        snap_q[c] <= '0;
      else if (rd && cpu_ok && int'(req_cpu) == c && widx == W_CNT_LO)
        snap_q[c] <= count[CNT_W-1:32];
    end

    gt_bank #(.CNT_W(CNT_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .count_i     (count),
      .ctl_i       (bctl_q[c]),
      .wr_cmp_lo_i (mine && widx == W_CMP_LO),
      .wr_cmp_hi_i (mine && widx == W_CMP_HI),
      .wr_inc_i    (mine && widx == W_INC),
      .clr_i       (mine && widx == W_STAT && req_wdata[0]),
      .wdata_i     (req_wdata),
      .cmp_o       (cmp_w[c]),
      .inc_o       (inc_w[c]),
      .flag_o      (flag_w[c]),
      .irq_o       (irq_o[c])
    );
  end

  always_comb begin
    rdata = '0;
    if (cpu_ok) begin
      unique case (widx)
        W_CNT_LO: rdata = count[31:0];
        W_CNT_HI: rdata[HI_W-1:0] = snap_q[req_cpu];
        W_CTRL: begin
          rdata[B_RUN]              = run_q;
          rdata[B_CMP_EN]           = bctl_q[req_cpu].cmp_en;
          rdata[B_IRQ_EN]           = bctl_q[req_cpu].irq_en;
          rdata[B_AUTO]             = bctl_q[req_cpu].auto_inc;
          rdata[B_PRE_LSB +: PRE_W] = presc_q;
        end
        W_STAT:   rdata[0] = flag_w[req_cpu];
        W_CMP_LO: rdata = cmp_w[req_cpu][31:0];
        W_CMP_HI: rdata[HI_W-1:0] = cmp_w[req_cpu][CNT_W-1:32];
        W_INC:    rdata = inc_w[req_cpu];
        default:  rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rdata;
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R10

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid); // R10

  AST_RUN_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && widx == W_CTRL) |=> $stable(run_q)); // R4

endmodule

// File: tb/tb_gtimer_cluster.sv
module tb_gtimer_cluster;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [4:0]  req_addr;
  logic [31:0] req_wdata;
  logic [1:0]  req_cpu;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [3:0]  irq_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  gtimer_cluster dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [4:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_cpu = cpu[1:0];
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [4:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_cpu = cpu[1:0];
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] e;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_cpu = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("reset irq", {60'b0, irq_o}, 64'h0);
    rd(0, 5'h08, d); chk("reset ctrl R4", {32'b0, d}, 64'h0);
    rd(0, 5'h00, d); chk("reset counter R1", {32'b0, d}, 64'h0);

    // R10: response timing and unmapped offset
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h1C; req_cpu = 2'd1;
    @(negedge clk); req_valid = 1'b0;
    chk("R10 rsp_valid", {63'b0, rsp_valid}, 64'h1);
    chk("R10 unmapped reads zero", {32'b0, rsp_data}, 64'h0);
    @(negedge clk);
    chk("R10 rsp_valid single", {63'b0, rsp_valid}, 64'h0);

    // R1 / R2: prescaler and run-length sweep
    for (int p = 0; p < 6; p++) begin
      for (int w = 0; w < 12; w += 3) begin
        wr(0, 5'h08, 32'h0);
        wr(0, 5'h00, 32'h0);
        wr(0, 5'h04, 32'h0);
        wr(0, 5'h08, (p << 8) | 1);
        repeat (w) @(negedge clk);
        wr(0, 5'h08, p << 8);
        rd(0, 5'h00, d);
        chk($sformatf("R1 count p=%0d w=%0d", p, w), {32'b0, d}, 64'((w + 1) / (p + 1)));
        repeat (4) @(negedge clk);
        rd(0, 5'h00, d);
        chk("R2 hold while off", {32'b0, d}, 64'((w + 1) / (p + 1)));
      end
    end

    // R2: counter write while running is ignored
    wr(0, 5'h08, 32'h0);
    wr(0, 5'h00, 32'h0);
    wr(0, 5'h08, 32'h1);
    wr(0, 5'h00, 32'h0000FFFF);
    wr(0, 5'h08, 32'h0);
    rd(0, 5'h00, d);
    chk("R2 write while running ignored", {32'b0, d}, 64'd2);

    // R3: high-word snapshot per core
    wr(0, 5'h00, 32'hFFFFFFFF);
    wr(0, 5'h04, 32'h12345678);
    rd(1, 5'h00, d);
    wr(0, 5'h04, 32'h0000AAAA);
    rd(1, 5'h04, d); chk("R3 stale snapshot core1", {32'b0, d}, 64'h12345678);
    rd(0, 5'h00, d);
    rd(0, 5'h04, d); chk("R3 fresh snapshot core0", {32'b0, d}, 64'h0000AAAA);

    // R4: merged control view
    wr(1, 5'h08, 32'h0000_0506);
    wr(2, 5'h08, 32'h0000_0308);
    rd(1, 5'h08, d); chk("R4 core1 view", {32'b0, d}, 64'h0306);
    rd(2, 5'h08, d); chk("R4 core2 view", {32'b0, d}, 64'h0308);
    wr(1, 5'h08, 32'h0);
    wr(2, 5'h08, 32'h0);

    // R5: bank isolation
    wr(0, 5'h10, 32'hA0A0_0001);
    wr(3, 5'h10, 32'hB0B0_0003);
    wr(3, 5'h18, 32'h77);
    rd(0, 5'h10, d); chk("R5 core0 cmp", {32'b0, d}, 64'hA0A00001);
    rd(3, 5'h10, d); chk("R5 core3 cmp", {32'b0, d}, 64'hB0B00003);
    rd(0, 5'h18, d); chk("R5 core0 inc untouched", {32'b0, d}, 64'h0);

    // R6 / R7 / R8: compare sweep on every core, 64-bit values
    for (int c = 0; c < 4; c++) begin
      for (int dd = -2; dd <= 2; dd++) begin
        int  k;
        bit  ie;
        bit  ex;
        k  = 1000 + c * 7;
        ie = ((c + dd + 4) % 2) == 1;
        ex = (dd >= 0);
        wr(c, 5'h08, 32'h0);
        wr(c, 5'h0C, 32'h1);
        wr(c, 5'h00, 32'(k + dd));
        wr(c, 5'h04, 32'h1);
        wr(c, 5'h10, 32'(k));
        wr(c, 5'h14, 32'h1);
        wr(c, 5'h08, ie ? 32'h6 : 32'h2);
        @(negedge clk);
        rd(c, 5'h0C, d);
        chk($sformatf("R6 flag core%0d d=%0d", c, dd), {32'b0, d}, {63'b0, ex});
        chk("R8 irq line", {63'b0, irq_o[c]}, {63'b0, ex & ie});
        chk("R5 other irqs quiet", {60'b0, irq_o & ~(4'b1 << c)}, 64'h0);
        wr(c, 5'h0C, 32'h1);
        rd(c, 5'h0C, d);
        chk("R7 set wins over clear", {32'b0, d}, {63'b0, ex});
        wr(c, 5'h08, ie ? 32'h4 : 32'h0);
        wr(c, 5'h0C, 32'h1);
        rd(c, 5'h0C, d);
        chk("R7 clear", {32'b0, d}, 64'h0);
        wr(c, 5'h08, 32'h0);
      end
    end

    // R9: auto-increment, two configurations on core 2
    for (int t = 0; t < 2; t++) begin
      int c0, inc, p, w, v;
      c0  = (t == 0) ? 10 : 3;
      inc = (t == 0) ? 5 : 7;
      p   = (t == 0) ? 0 : 1;
      w   = (t == 0) ? 20 : 30;
      wr(2, 5'h08, 32'h0);
      wr(2, 5'h00, 32'h0);
      wr(2, 5'h04, 32'h0);
      wr(2, 5'h10, 32'(c0));
      wr(2, 5'h14, 32'h0);
      wr(2, 5'h18, 32'(inc));
      wr(2, 5'h0C, 32'h1);
      wr(2, 5'h08, (p << 8) | 32'hB);
      repeat (w) @(negedge clk);
      wr(2, 5'h08, (p << 8) | 32'hA);
      repeat (3) @(negedge clk);
      v = (w + 1) / (p + 1);
      e = 64'(c0);
      while (e <= 64'(v)) e += 64'(inc);
      rd(2, 5'h10, d);
      chk($sformatf("R9 comparator t=%0d", t), {32'b0, d}, e);
      rd(2, 5'h0C, d);
      chk("R9 flag after auto hits", {32'b0, d}, 64'h1);
      wr(2, 5'h08, 32'h0);
      wr(2, 5'h0C, 32'h1);
    end

    finish_run();
  end
endmodule